// File: doc/BRIEF.md
# Index Pulse Distance Meter

This block measures how many encoder counts lie between successive index pulses on one encoder channel. A quadrature decoder upstream gives it a count strobe with a direction bit. It also receives an index level that has already been synchronised to the clock. An internal running counter follows the strobes, and it restarts whenever the index level rises.

Two result registers hold distances. The first holds the span between the first two index pulses after reset and is written only once. The second is rewritten on every index pulse from the second onward, so it always holds the latest span. Valid flags and an overflow flag go to a status reader. Reading status clears the flags for the latest span and for overflow. The bit-width of the counter is a parameter and defaults to 24.

Top module: `idx_span_meter`

## Requirements
- R1: After reset `first_span` and `last_span` are zero, and `first_valid`, `last_valid` and `span_ovf` are low.
- R2: Each cycle with `cnt_en` high adds one to the running count when `cnt_dir` is 1. It subtracts one when `cnt_dir` is 0. A count of zero is never decremented. Cycles with `cnt_en` low leave the count unchanged.
- R3: An index event is a cycle in which `index_lvl` is 1 while it was 0 in the previous cycle. Holding the level at 1 produces no further events.
- R4: The first index event after reset captures nothing. It only starts the measurement, and all outputs keep their reset values.
- R5: At the second index event, the count accumulated since the first event is written to both `first_span` and `last_span`. `first_valid` rises on the next clock edge.
- R6: After it is written, `first_span` never changes and `first_valid` stays high until reset.
- R7: Every index event after the first writes the accumulated count to `last_span`. In the same cycle the running count restarts at zero. A strobe in that same cycle already counts toward the new span.
- R8: `last_valid` is set by every capture into `last_span` and is cleared by a cycle with `stat_rd` high. If both happen in the same cycle, the capture wins.
- R9: The running count saturates at 2^W-1. An up strobe at that value sets `span_ovf`. `span_ovf` stays set until a `stat_rd` cycle, and a set in the same cycle as `stat_rd` wins.
- R10: With default parameters the counter and both result registers are 24 bits wide, so spans above 255 are captured without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count strobe from the decoder |
| cnt_dir | input | 1 | Count direction, 1 = up, 0 = down |
| index_lvl | input | 1 | Synchronised index level |
| stat_rd | input | 1 | Status read strobe, clears `last_valid` and `span_ovf` |
| first_span | output | W | Span between the first two index events |
| first_valid | output | 1 | `first_span` holds a result |
| last_span | output | W | Span between the two latest index events |
| last_valid | output | 1 | New `last_span` since the last status read |
| span_ovf | output | 1 | The running count saturated |

## Verification
Random strobes with an upward bias are mixed with index pulses, first at short intervals and then at long ones. The short intervals exercise the capture and restart rules over many spans. The long intervals drive a narrow 8-bit instance into saturation while the default instance shows that a 24-bit span is preserved. Directed runs cover the following cases:
- A held index level, which separates level detection from edge detection.
- Down strobes at zero, which show the floor.
- A status read coinciding with a capture, which shows that the set has priority.

// File: rtl/idx_span_meter.sv
module idx_span_meter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         cnt_dir,
  input  logic         index_lvl,
  input  logic         stat_rd,
  output logic [W-1:0] first_span,
  output logic         first_valid,
  output logic [W-1:0] last_span,
  output logic         last_valid,
  output logic         span_ovf
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         idx_q, armed, rise, sat_hit;
  logic [W-1:0] cnt, base, cnt_nx;

  assign rise    = index_lvl & ~idx_q;
  assign base    = rise ? '0 : cnt;
  assign sat_hit = cnt_en & cnt_dir & (base == MAXV);

  always_comb begin
    cnt_nx = base;
    if (cnt_en) begin
      if (cnt_dir) cnt_nx = (base == MAXV) ? base : base + 1'b1;
      else         cnt_nx = (base == '0)   ? base : base - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q       <= 1'b0;
      armed       <= 1'b0;
      cnt         <= '0;
      first_span  <= '0;
      first_valid <= 1'b0;
      last_span   <= '0;
      last_valid  <= 1'b0;
      span_ovf    <= 1'b0;
    end else begin
      idx_q <= index_lvl;
      cnt   <= cnt_nx;
      if (rise) armed <= 1'b1;
      if (rise && armed) begin
        last_span  <= cnt;
        last_valid <= 1'b1;
        if (!first_valid) begin
          first_span  <= cnt;
          first_valid <= 1'b1;
        end
      end else if (stat_rd) begin
        last_valid <= 1'b0;
      end
      if (sat_hit)      span_ovf <= 1'b1;
      else if (stat_rd) span_ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/idx_span_meter_chk.sv
module idx_span_meter_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         cnt_dir,
  input logic         stat_rd,
  input logic         rise,
  input logic [W-1:0] cnt,
  input logic [W-1:0] first_span,
  input logic         first_valid,
  input logic         last_valid,
  input logic         span_ovf
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  AST_FIRST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    first_valid |=> first_valid);  // R6
  AST_FIRST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    first_valid |=> $stable(first_span));  // R6
  AST_LAST_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    last_valid |-> first_valid);  // R5
  AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && cnt_en && cnt_dir && cnt != MAXV) |=> cnt == $past(cnt) + 1'b1);  // R2
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !cnt_en) |=> cnt == '0);  // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && cnt == MAXV) |=> cnt == MAXV || cnt == MAXV - 1'b1 || $past(rise) || cnt == '0 || 1'b1 == $past(cnt_en && !cnt_dir) || 1'b1 == !$past(cnt_en) && cnt == MAXV);  // R9
  AST_OVF_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(span_ovf) |-> cnt == MAXV);  // R9
  AST_LAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rise) |=> !last_valid);  // R8
endmodule

bind idx_span_meter idx_span_meter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_dir(cnt_dir),
  .stat_rd(stat_rd), .rise(rise), .cnt(cnt), .first_span(first_span),
  .first_valid(first_valid), .last_valid(last_valid), .span_ovf(span_ovf)
);

// File: tb/sim_idx_span_meter.sv
module sim_idx_span_meter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 1'b0, cnt_dir = 1'b0, index_lvl = 1'b0, stat_rd = 1'b0;
  logic [23:0] f0, l0;
  logic [7:0]  f1, l1;
  logic fv0, lv0, ov0, fv1, lv1, ov1;
  int errors = 0, checks = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  idx_span_meter u0 (.clk, .rst_n, .cnt_en, .cnt_dir, .index_lvl, .stat_rd,
    .first_span(f0), .first_valid(fv0), .last_span(l0), .last_valid(lv0), .span_ovf(ov0));
  idx_span_meter #(.W(8)) u1 (.clk, .rst_n, .cnt_en, .cnt_dir, .index_lvl, .stat_rd,
    .first_span(f1), .first_valid(fv1), .last_span(l1), .last_valid(lv1), .span_ovf(ov1));

  logic [23:0] m_cnt[2], m_first[2], m_last[2];
  logic        m_prev[2], m_arm[2], m_fv[2], m_lv[2], m_ov[2];

  function automatic logic [23:0] mx(int i);
    return (i == 0) ? 24'hFFFFFF : 24'h0000FF;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = 0; m_first[i] = 0; m_last[i] = 0;
      m_prev[i] = 0; m_arm[i] = 0; m_fv[i] = 0; m_lv[i] = 0; m_ov[i] = 0;
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < 2; i++) begin
      logic r;
      logic [23:0] b;
      r = index_lvl && !m_prev[i];
      b = r ? 24'd0 : m_cnt[i];
      if (r && m_arm[i]) begin
        m_last[i] = m_cnt[i];
        if (!m_fv[i]) begin m_first[i] = m_cnt[i]; m_fv[i] = 1; end
        m_lv[i] = 1;
      end else if (stat_rd) m_lv[i] = 0;
      if (cnt_en && cnt_dir && b == mx(i)) m_ov[i] = 1;
      else if (stat_rd) m_ov[i] = 0;
      if (cnt_en) begin
        if (cnt_dir) b = (b == mx(i)) ? b : b + 1;
        else         b = (b == 0) ? b : b - 1;
      end
      m_cnt[i] = b;
      m_arm[i] = m_arm[i] | r;
      m_prev[i] = index_lvl;
    end
  endtask

  task automatic chk(string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("first_span",  f0, m_first[0]);
    chk("first_valid", {23'd0, fv0}, {23'd0, m_fv[0]});
    chk("last_span",   l0, m_last[0]);
    chk("last_valid",  {23'd0, lv0}, {23'd0, m_lv[0]});
    chk("span_ovf",    {23'd0, ov0}, {23'd0, m_ov[0]});
    chk("w8 first_span", {16'd0, f1}, m_first[1]);
    chk("w8 last_span",  {16'd0, l1}, m_last[1]);
    chk("w8 last_valid", {23'd0, lv1}, {23'd0, m_lv[1]});
    chk("w8 span_ovf",   {23'd0, ov1}, {23'd0, m_ov[1]});
  endtask

  task automatic cyc(logic e, logic d, logic ix, logic rd);
    @(negedge clk);
    compare();
    cnt_en = e; cnt_dir = d; index_lvl = ix; stat_rd = rd;
    model_step();
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    tag = "R4";
    cyc(1, 1, 0, 0); cyc(1, 1, 1, 0);
    repeat (5) cyc(1, 1, 1, 0);
    tag = "R3";
    repeat (10) cyc(1, 1, 1, 0);
    cyc(0, 0, 0, 0);
    tag = "R2";
    repeat (20) cyc(1, 0, 0, 0);
    repeat (7) cyc(1, 1, 0, 0);
    repeat (4) cyc(0, 0, 0, 0);
    tag = "R5";
    cyc(1, 1, 1, 0); cyc(0, 0, 0, 0);
    tag = "R8";
    repeat (3) cyc(1, 1, 0, 0);
    cyc(0, 0, 1, 1); cyc(0, 0, 0, 0); cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);
    tag = "R7";
    for (int n = 0; n < 12000; n++) begin
      logic ix;
      ix = ($urandom_range(0, 39) == 0) ? ~index_lvl : index_lvl;
      cyc($urandom_range(0, 1), $urandom_range(0, 3) != 0, ix, $urandom_range(0, 15) == 0);
    end
    tag = "R9";
    for (int n = 0; n < 4000; n++)
      cyc($urandom_range(0, 1), $urandom_range(0, 3) != 0, 0, $urandom_range(0, 200) == 0);
    tag = "R10";
    cyc(0, 0, 1, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    chk("span above 255", {23'd0, l0 > 24'd255}, 24'd1);
    tag = "R6";
    for (int n = 0; n < 3000; n++) begin
      logic ix;
      ix = ($urandom_range(0, 29) == 0) ? ~index_lvl : index_lvl;
      cyc($urandom_range(0, 1), $urandom(), ix, $urandom_range(0, 7) == 0);
    end
    @(negedge clk); compare();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule